// File: doc/BRIEF.md
# Test Access Port Controller with Instruction Decode

This block is the serial test port of a chip. It runs the sixteen-state test state machine on the rising edge of the test clock and follows the mode-select input. It holds a small instruction register and decodes it to pick the data path that sits between the serial input and the serial output. The choices are a one-bit pass-through register, a 32-bit identification register, and an external boundary-scan chain. That chain is reached through a return input and three strobes that the controller generates. The block needs no dedicated test reset pin. The chip's power-on reset puts it in Test-Logic-Reset, and from there the mode-select input alone can return it to that state at any time.

Five instructions are decoded. Two of them route the boundary chain: one samples the pins and one drives them from the cells. A third routes the identification register. The last two route the one-bit register, and one of those also disables every chip output while it is active. Any other code behaves as the pass-through instruction. The serial output and its enable change on the falling clock edge. The enable is high only while a register is being shifted.

Top module: `scan_port_top`

## Requirements
- R1: While `porN` is low and after it is released, the controller is in Test-Logic-Reset, the active instruction is IDCODE (code 4'b0010), `tdoOe`, `outDisable` and `bsDrive` are low, and a data scan taken right after reset returns the identification value.
- R2: Five rising `tck` edges with `tms` high bring the controller to Test-Logic-Reset from any state, and the active instruction becomes IDCODE again.
- R3: Capture-IR loads the instruction shift register with 4'b0001 (binary 01 in the two low bits, zeros above), and that value leaves on `tdo`, least significant bit first.
- R4: With IDCODE active, Capture-DR loads the 32-bit `ID_VALUE`, which shifts out on `tdo` least significant bit first. Bits shifted in at `tdi` follow it after 32 shifts.
- R5: BYPASS (code 4'b1111) selects a one-bit register that captures 0, so `tdo` repeats `tdi` one shift later.
- R6: A code that is not one of the five (for example 4'b0101) behaves exactly as BYPASS.
- R7: HIGHZ (code 4'b0011) selects the one-bit register and holds `outDisable` high for as long as it is the active instruction. `outDisable` rises only during Update-IR.
- R8: SAMPLE (4'b0001) and EXTEST (4'b0000) route the boundary chain. `bsCapture`, `bsShift` and `bsUpdate` are high only in Capture-DR, Shift-DR and Update-DR respectively, and never two at once. `bsReturn` appears on `tdo`. `bsDrive` is high only under EXTEST. The strobes stay low when the chain is not selected.
- R9: `tdoOe` is high only during Shift-DR and Shift-IR, and it changes on the falling edge of `tck`.
- R10: The active instruction changes only in Update-IR or Test-Logic-Reset. Shifting a new code through the instruction register does not alter `outDisable` or `bsDrive` until Update-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| porN | input | 1 | Chip power-on reset, active low, asynchronous |
| tms | input | 1 | Test mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial test data in, sampled on rising `tck` |
| tdo | output | 1 | Serial test data out, updated on falling `tck` |
| tdoOe | output | 1 | Output enable for `tdo` pad |
| bsReturn | input | 1 | Serial output of the external boundary chain |
| bsCapture | output | 1 | Boundary chain capture enable (Capture-DR, chain selected) |
| bsShift | output | 1 | Boundary chain shift enable (Shift-DR, chain selected) |
| bsUpdate | output | 1 | Boundary chain update strobe (Update-DR, chain selected) |
| bsDrive | output | 1 | Boundary cells drive the pins (EXTEST active) |
| outDisable | output | 1 | Global output disable (HIGHZ active) |

## Verification
The hardest condition to reach from the ports is a return to Test-Logic-Reset from deep inside a scan. The mode-select input has to walk the controller into Shift-DR under a non-default instruction, and the five-ones escape has to start from there. After the escape, the bench confirms through a fresh data scan that the identification register is selected again. It also loads HIGHZ and escapes the same way, to confirm that the output disable drops. The other hard case is Update-IR timing. While the HIGHZ code is being shifted in, the bench watches `outDisable` on every shift and in Exit1-IR, and it must not change before the update state.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;

  localparam int ID_W = 32;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UP_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UP_IR
  } tapState_e;

  typedef struct packed {
    logic resetTl;
    logic captureDr;
    logic shiftDr;
    logic updateDr;
    logic captureIr;
    logic shiftIr;
    logic updateIr;
  } tapCtl_t;

  typedef enum logic [1:0] {SEL_BYPASS, SEL_ID, SEL_CHAIN} drSel_e;

endpackage

// File: rtl/scan_port_fsm.sv
module scan_port_fsm
  import scan_port_pkg::*;
(
  input  logic    tck,
  input  logic    porN,
  input  logic    tms,
  output tapCtl_t ctl
);

  tapState_e state, nextState;

  always_comb begin
    nextState = state;
    case (state)
      ST_TLR:    nextState = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nextState = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nextState = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nextState = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nextState = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nextState = tms ? ST_UP_DR  : ST_PA_DR;
      ST_PA_DR:  nextState = tms ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: nextState = tms ? ST_UP_DR  : ST_SH_DR;
      ST_UP_DR:  nextState = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nextState = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nextState = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nextState = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nextState = tms ? ST_UP_IR  : ST_PA_IR;
      ST_PA_IR:  nextState = tms ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: nextState = tms ? ST_UP_IR  : ST_SH_IR;
      ST_UP_IR:  nextState = tms ? ST_SEL_DR : ST_RTI;
      default:   nextState = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge porN) begin
    if (!porN) state <= ST_TLR;
    else       state <= nextState;
  end

  always_comb begin
    ctl.resetTl   = (state == ST_TLR);
    ctl.captureDr = (state == ST_CAP_DR);
    ctl.shiftDr   = (state == ST_SH_DR);
    ctl.updateDr  = (state == ST_UP_DR);
    ctl.captureIr = (state == ST_CAP_IR);
    ctl.shiftIr   = (state == ST_SH_IR);
    ctl.updateIr  = (state == ST_UP_IR);
  end

endmodule

// File: rtl/scan_port_regs.sv
module scan_port_regs
  import scan_port_pkg::*;
#(
  parameter int                IR_W      = 4,
  parameter logic [ID_W-1:0]   ID_VALUE  = 32'h149A_703F,
  parameter logic [IR_W-1:0]   OP_EXTEST = '0,
  parameter logic [IR_W-1:0]   OP_SAMPLE = IR_W'(1),
  parameter logic [IR_W-1:0]   OP_IDCODE = IR_W'(2),
  parameter logic [IR_W-1:0]   OP_HIGHZ  = IR_W'(3)
)(
  input  logic            tck,
  input  logic            porN,
  input  logic            tdi,
  input  tapCtl_t         ctl,
  input  logic            bsReturn,
  output logic            tdo,
  output logic            tdoOe,
  output logic [IR_W-1:0] irActive,
  output logic            bsCapture,
  output logic            bsShift,
  output logic            bsUpdate,
  output logic            bsDrive,
  output logic            outDisable
);

  localparam logic [IR_W-1:0] IR_CAPTURE = IR_W'(2'b01);

  logic [IR_W-1:0] irShift;
  logic [ID_W-1:0] idShift;
  logic            bypassBit;
  drSel_e          drSel;

  always_comb begin
    if (irActive == OP_IDCODE)
      drSel = SEL_ID;
    else if (irActive == OP_SAMPLE || irActive == OP_EXTEST)
      drSel = SEL_CHAIN;
    else
      drSel = SEL_BYPASS;
  end

  assign bsCapture  = ctl.captureDr && (drSel == SEL_CHAIN);
  assign bsShift    = ctl.shiftDr   && (drSel == SEL_CHAIN);
  assign bsUpdate   = ctl.updateDr  && (drSel == SEL_CHAIN);
  assign bsDrive    = (irActive == OP_EXTEST);
  assign outDisable = (irActive == OP_HIGHZ);

  // Capture and shift act on the rising edge
  always_ff @(posedge tck or negedge porN) begin
    if (!porN) begin
      irShift   <= IR_CAPTURE;
      idShift   <= '0;
      bypassBit <= 1'b0;
    end else begin
      if (ctl.captureIr)    irShift <= IR_CAPTURE;
      else if (ctl.shiftIr) irShift <= {tdi, irShift[IR_W-1:1]};

      if (ctl.captureDr) begin
        bypassBit <= 1'b0;
        if (drSel == SEL_ID) idShift <= ID_VALUE;
      end else if (ctl.shiftDr) begin
        bypassBit <= tdi;
        if (drSel == SEL_ID) idShift <= {tdi, idShift[ID_W-1:1]};
      end
    end
  end

  // Instruction update and serial output act on the falling edge
  always_ff @(negedge tck or negedge porN) begin
    if (!porN) begin
      irActive <= OP_IDCODE;
      tdo      <= 1'b0;
      tdoOe    <= 1'b0;
    end else begin
      if (ctl.resetTl)       irActive <= OP_IDCODE;
      else if (ctl.updateIr) irActive <= irShift;

      tdoOe <= ctl.shiftDr || ctl.shiftIr;
      if (ctl.shiftIr)
        tdo <= irShift[0];
      else if (ctl.shiftDr) begin
        case (drSel)
          SEL_ID:    tdo <= idShift[0];
          SEL_CHAIN: tdo <= bsReturn;
          default:   tdo <= bypassBit;
        endcase
      end
    end
  end

endmodule

// File: rtl/scan_port_top.sv
module scan_port_top
  import scan_port_pkg::*;
#(
  parameter int              IR_W      = 4,
  parameter logic [ID_W-1:0] ID_VALUE  = 32'h149A_703F,
  parameter logic [IR_W-1:0] OP_EXTEST = '0,
  parameter logic [IR_W-1:0] OP_SAMPLE = IR_W'(1),
  parameter logic [IR_W-1:0] OP_IDCODE = IR_W'(2),
  parameter logic [IR_W-1:0] OP_HIGHZ  = IR_W'(3)
)(
  input  logic tck,
  input  logic porN,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdoOe,
  input  logic bsReturn,
  output logic bsCapture,
  output logic bsShift,
  output logic bsUpdate,
  output logic bsDrive,
  output logic outDisable
);

  tapCtl_t         ctl;
  logic [IR_W-1:0] irActive;

  scan_port_fsm u_fsm (
    .tck  (tck),
    .porN (porN),
    .tms  (tms),
    .ctl  (ctl)
  );

  scan_port_regs #(
    .IR_W      (IR_W),
    .ID_VALUE  (ID_VALUE),
    .OP_EXTEST (OP_EXTEST),
    .OP_SAMPLE (OP_SAMPLE),
    .OP_IDCODE (OP_IDCODE),
    .OP_HIGHZ  (OP_HIGHZ)
  ) u_regs (
    .tck        (tck),
    .porN       (porN),
    .tdi        (tdi),
    .ctl        (ctl),
    .bsReturn   (bsReturn),
    .tdo        (tdo),
    .tdoOe      (tdoOe),
    .irActive   (irActive),
    .bsCapture  (bsCapture),
    .bsShift    (bsShift),
    .bsUpdate   (bsUpdate),
    .bsDrive    (bsDrive),
    .outDisable (outDisable)
  );

endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk
  import scan_port_pkg::*;
#(
  parameter int              IR_W      = 4,
  parameter logic [IR_W-1:0] OP_IDCODE = IR_W'(2)
)(
  input logic            tck,
  input logic            porN,
  input logic            tms,
  input tapCtl_t         ctl,
  input logic [IR_W-1:0] irActive,
  input logic            tdoOe,
  input logic            outDisable,
  input logic            bsCapture,
  input logic            bsShift,
  input logic            bsUpdate
);

  logic [2:0] onesRun;

  always_ff @(posedge tck or negedge porN) begin
    if (!porN)   onesRun <= '0;
    else if (tms) onesRun <= (onesRun == 3'd7) ? onesRun : onesRun + 3'd1;
    else         onesRun <= '0;
  end

  p_tlr_ir_r1: assert property (@(posedge tck) disable iff (!porN)
    ctl.resetTl |-> irActive == OP_IDCODE);

  p_five_ones_r2: assert property (@(posedge tck) disable iff (!porN)
    (tms && onesRun >= 3'd4) |=> ctl.resetTl);

  p_highz_rise_r7: assert property (@(posedge tck) disable iff (!porN)
    $rose(outDisable) |-> ctl.updateIr);

  p_bs_excl_r8: assert property (@(posedge tck) disable iff (!porN)
    $onehot0({bsCapture, bsShift, bsUpdate}));

  p_oe_shift_r9: assert property (@(posedge tck) disable iff (!porN)
    tdoOe |-> (ctl.shiftDr || ctl.shiftIr));

  p_ir_hold_r10: assert property (@(posedge tck) disable iff (!porN)
    (!ctl.updateIr && !ctl.resetTl) |-> $stable(irActive));

endmodule

bind scan_port_top scan_port_chk #(
  .IR_W      (IR_W),
  .OP_IDCODE (OP_IDCODE)
) u_chk (
  .tck        (tck),
  .porN       (porN),
  .tms        (tms),
  .ctl        (ctl),
  .irActive   (irActive),
  .tdoOe      (tdoOe),
  .outDisable (outDisable),
  .bsCapture  (bsCapture),
  .bsShift    (bsShift),
  .bsUpdate   (bsUpdate)
);

// File: tb/scan_port_top_test.sv
`timescale 1ns/1ps
module scan_port_top_test;

  localparam logic [31:0] ID = 32'h149A_703F;
  localparam logic [3:0] C_EXTEST = 4'b0000, C_SAMPLE = 4'b0001,
                         C_IDCODE = 4'b0010, C_HIGHZ = 4'b0011,
                         C_BYPASS = 4'b1111, C_UNUSED = 4'b0101;
  localparam logic [7:0] PINS = 8'hA6;

  logic tck = 1'b0, porN = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdoOe, bsReturn, bsCapture, bsShift, bsUpdate, bsDrive, outDisable;
  int total = 0, bad = 0;
  int oeMiss = 0, shiftCnt = 0, updCnt = 0;
  logic sawDisable;
  logic [7:0] chainReg = '0, chainUpd = '0;

  always #4 tck = ~tck;

  scan_port_top uut (
    .tck(tck), .porN(porN), .tms(tms), .tdi(tdi), .tdo(tdo), .tdoOe(tdoOe),
    .bsReturn(bsReturn), .bsCapture(bsCapture), .bsShift(bsShift),
    .bsUpdate(bsUpdate), .bsDrive(bsDrive), .outDisable(outDisable)
  );

  // external boundary chain model
  assign bsReturn = chainReg[0];
  always @(posedge tck) begin
    if (bsCapture) chainReg <= PINS;
    else if (bsShift) begin
      chainReg <= {tdi, chainReg[7:1]};
      shiftCnt <= shiftCnt + 1;
    end
  end
  always @(negedge tck) if (bsUpdate) begin
    chainUpd <= chainReg;
    updCnt   <= updCnt + 1;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic doIr(input logic [3:0] code, output logic [3:0] cap);
    cap = '0;
    sawDisable = outDisable;
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) begin
      cap[i] = tdo;
      if (!tdoOe) oeMiss++;
      if (outDisable) sawDisable = 1'b1;
      step(i == 3, code[i]);
    end
    if (outDisable) sawDisable = 1'b1;
    step(1, 0); step(0, 0);
  endtask

  task automatic doDr(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      if (!tdoOe) oeMiss++;
      step(i == n - 1, din[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic t_reset;
    logic [63:0] d;
    check("R1 tdoOe", tdoOe, 0);
    check("R1 outDisable", outDisable, 0);
    check("R1 bsDrive", bsDrive, 0);
    step(0, 0);
    doDr(32, '0, d);
    check("R1 idcode after reset", d[31:0], ID);
  endtask

  task automatic t_irCapture;
    logic [3:0] c;
    doIr(C_BYPASS, c);
    check("R3 capture-ir", c, 4'b0001);
  endtask

  task automatic t_bypass;
    logic [63:0] d;
    logic [3:0] c;
    int s0;
    doIr(C_BYPASS, c);
    s0 = shiftCnt;
    doDr(8, 64'hB5, d);
    check("R5 bypass", d[7:0], 8'h6A);
    check("R8 no chain shift in bypass", shiftCnt, s0);
    doIr(C_UNUSED, c);
    doDr(8, 64'h4E, d);
    check("R6 unused code", d[7:0], 8'h9C);
  endtask

  task automatic t_idcode;
    logic [63:0] d;
    logic [3:0] c;
    doIr(C_IDCODE, c);
    doDr(40, 64'hC3, d);
    check("R4 id value", d[31:0], ID);
    check("R4 trailing tdi", d[39:32], 8'hC3);
  endtask

  task automatic t_highz;
    logic [63:0] d;
    logic [3:0] c;
    doIr(C_HIGHZ, c);
    check("R10 no early disable", sawDisable, 0);
    check("R7 disable on", outDisable, 1);
    doDr(8, 64'h2D, d);
    check("R7 bypass path", d[7:0], 8'h5A);
    check("R7 still on", outDisable, 1);
    doIr(C_BYPASS, c);
    check("R7 disable off", outDisable, 0);
  endtask

  task automatic t_chain;
    logic [63:0] d;
    logic [3:0] c;
    int u0;
    doIr(C_SAMPLE, c);
    check("R8 sample no drive", bsDrive, 0);
    u0 = updCnt;
    doDr(8, 64'h3C, d);
    check("R8 captured pins", d[7:0], PINS);
    check("R8 chain loaded", chainReg, 8'h3C);
    check("R8 update strobe", updCnt - u0, 1);
    check("R8 updated value", chainUpd, 8'h3C);
    doIr(C_EXTEST, c);
    check("R8 extest drive", bsDrive, 1);
    check("R10 extest no disable", outDisable, 0);
  endtask

  task automatic t_oe;
    step(1, 0); step(0, 0);
    check("R9 oe off in capture-dr", tdoOe, 0);
    step(0, 0);
    check("R9 oe on in shift-dr", tdoOe, 1);
    step(1, 0);
    check("R9 oe off in exit1", tdoOe, 0);
    step(1, 0); step(0, 0);
    check("R9 oe in every shift", oeMiss, 0);
  endtask

  task automatic t_escape;
    logic [63:0] d;
    logic [3:0] c;
    doIr(C_BYPASS, c);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 5; i++) step(1, 0);
    step(0, 0);
    doDr(32, '0, d);
    check("R2 idcode after five ones", d[31:0], ID);
    doIr(C_HIGHZ, c);
    for (int i = 0; i < 5; i++) step(1, 0);
    check("R2 highz cleared", outDisable, 0);
    step(0, 0);
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #21;
    porN = 1'b1;
    @(negedge tck); #1;
    t_reset;
    t_irCapture;
    t_bypass;
    t_idcode;
    t_highz;
    t_chain;
    t_oe;
    t_escape;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule